// File: doc/BRIEF.md
# Multi-domain soft reset sequencer

This block produces timed reset pulses for the internal domains of a network controller. Software writes a bit mask into the upper half of a 32-bit control word. Every set bit in that mask starts a reset pulse of fixed length on its own domain output. A single busy flag covers all of the domains. Software polls the flag until it clears, and so learns that every reset it asked for has finished.

The lower half of the same control word holds a force-interrupt trigger. It produces a one-cycle interrupt request pulse. The two halves of the word carry separate write enables, so a write can touch either half or both.

Every pulse lasts `PULSE_CYCLES` clock cycles, 64 by default. Software allows about 1 ms for the whole reset, so the pulse count must stay far below one millisecond's worth of cycles at the clock in use.

Top module: `soft_reset_seq`

## Requirements
- R1: After reset, every domain output, `busy`, `irq_force` and `rd_data` are all zero.
- R2: A write with `wr_be[1]` set and `wr_data[16+i]` set drives `dom_rst[i]` high for exactly `PULSE_CYCLES` cycles. The pulse starts in the cycle after the write edge.
- R3: Upper-half bits 0 to 6 (`wr_data[22:16]`) map to the global, receive, transmit, DMA, FIFO, network and host domains, which are `dom_rst[0]` to `dom_rst[6]`. Upper-half bits 7 to 15 start no reset.
- R4: Writing 0x007F to the upper half starts all seven domain pulses in the same cycle, and they end in the same cycle.
- R5: Upper-half bit 10 (`rd_data[26]`) and the `busy` output are 1 exactly when at least one domain output is high.
- R6: A new request for a domain whose pulse is still running restarts that domain's count. Its pulse then ends `PULSE_CYCLES` cycles after the new write. Domains that were not requested keep their own count.
- R7: The request bits clear themselves. `rd_data` shows nothing except the busy flag at bit 26, and every other bit reads 0.
- R8: A write with `wr_be[0]` set and `wr_data[9]` set gives a one-cycle `irq_force` pulse in the cycle after the write edge. Lower-half writes with bit 9 clear give no pulse.
- R9: A write whose byte enable for a half is clear has no effect through that half, whatever its data bits hold. Writes with `wr_en` low have no effect at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 2 | Halfword enables: bit 1 is the upper half, bit 0 is the lower half |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read view of the control word (busy flag at bit 26) |
| dom_rst | output | 7 | Active-high reset pulse, one bit per domain |
| busy | output | 1 | High while any domain pulse is running |
| irq_force | output | 1 | One-cycle forced interrupt request |

## Verification
The bench measures the exact length of a single pulse and checks the first and the last high cycle. A design with an off-by-one count would give a pulse one cycle too long or too short. A re-request in the middle of a pulse must extend only the requested domain. A design that ignores the re-request, or reloads every domain, would end the pulses at the wrong time. Writes with the upper enable clear, or with only bits 7 to 15 set, must start nothing, and a design that decodes the whole word would assert resets there. Random streams mix overlapping requests, interrupt triggers and reads, and each cycle is compared against a bench model of the per-domain countdowns.

// File: rtl/soft_reset_seq.sv
module soft_reset_seq #(
  parameter int NUM_DOMAINS  = 7,
  parameter int PULSE_CYCLES = 64,
  parameter int BUSY_BIT     = 10,
  parameter int FORCE_BIT    = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_be,
  input  logic [31:0]            wr_data,
  output logic [31:0]            rd_data,
  output logic [NUM_DOMAINS-1:0] dom_rst,
  output logic                   busy,
  output logic                   irq_force
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

  logic                   hi_wr;
  logic                   lo_wr;
  logic [NUM_DOMAINS-1:0] req;

  assign hi_wr = wr_en && wr_be[1];
  assign lo_wr = wr_en && wr_be[0];
  assign req   = hi_wr ? wr_data[16 +: NUM_DOMAINS] : '0;

  for (genvar i = 0; i < NUM_DOMAINS; i++) begin : g_dom
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (req[i])      cnt <= LOAD;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
    assign dom_rst[i] = (cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_force <= 1'b0;
    else        irq_force <= lo_wr && wr_data[FORCE_BIT];
  end

  assign busy    = |dom_rst;
  assign rd_data = {{(15-BUSY_BIT){1'b0}}, busy, {BUSY_BIT{1'b0}}, 16'h0000};
endmodule

module soft_reset_seq_chk #(
  parameter int NUM_DOMAINS = 7,
  parameter int BUSY_BIT    = 10,
  parameter int FORCE_BIT   = 9
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [1:0]             wr_be,
  input logic [31:0]            wr_data,
  input logic [31:0]            rd_data,
  input logic [NUM_DOMAINS-1:0] dom_rst,
  input logic                   busy,
  input logic                   irq_force
);
  AST_RD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[16+BUSY_BIT] == (dom_rst != '0)); // R5
  AST_BUSY_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    busy == rd_data[16+BUSY_BIT]); // R5
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_force) |-> $past(wr_en && wr_be[0] && wr_data[FORCE_BIT])); // R8
  AST_IRQ_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[0] && wr_data[FORCE_BIT]) |=> irq_force); // R8
  for (genvar i = 0; i < NUM_DOMAINS; i++) begin : g_a
    AST_REQ_START: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_be[1] && wr_data[16+i]) |=> dom_rst[i]); // R2
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_rst[i]) |-> $past(wr_en && wr_be[1] && wr_data[16+i])); // R9
  end
endmodule

bind soft_reset_seq soft_reset_seq_chk #(
  .NUM_DOMAINS(NUM_DOMAINS), .BUSY_BIT(BUSY_BIT), .FORCE_BIT(FORCE_BIT)
) u_chk (.*);

// File: tb/soft_reset_seq_test.sv
module soft_reset_seq_test;
  localparam int N  = 7;
  localparam int PC = 64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_be = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [N-1:0] dom_rst;
  logic        busy, irq_force;

  int tests = 0, fails = 0;
  int exp_cnt [N];
  bit exp_irq = 0;

  always #5 clk = ~clk;

  soft_reset_seq #(.NUM_DOMAINS(N), .PULSE_CYCLES(PC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .dom_rst(dom_rst), .busy(busy), .irq_force(irq_force));

  function automatic logic [N-1:0] exp_mask();
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (exp_cnt[i] != 0);
    return m;
  endfunction

  function automatic logic [31:0] exp_rd();
    return (exp_mask() != 0) ? 32'h0400_0000 : 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2/R3 dom_rst"}, 32'(dom_rst), 32'(exp_mask()));
    chk({tag, " R5 busy"}, 32'(busy), 32'(exp_mask() != 0));
    chk({tag, " R7 rd_data"}, rd_data, exp_rd());
    chk({tag, " R8 irq_force"}, 32'(irq_force), 32'(exp_irq));
  endtask

  task automatic cyc(input bit en, input logic [1:0] be, input logic [31:0] d, input string tag);
    wr_en = en; wr_be = be; wr_data = d;
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      if (en && be[1] && d[16+i]) exp_cnt[i] = PC;
      else if (exp_cnt[i] > 0) exp_cnt[i]--;
    end
    exp_irq = en && be[0] && d[9];
    wr_en = 0; wr_be = 0; wr_data = 0;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(0, 2'b00, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int hi_len;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after release");

    // R2: exact pulse length on the receive domain
    cyc(1, 2'b10, 32'h0002_0000, "R2 start");
    hi_len = dom_rst[1] ? 1 : 0;
    for (int k = 0; k < PC + 4; k++) begin
      cyc(0, 2'b00, 0, "R2 run");
      if (dom_rst[1]) hi_len++;
    end
    chk("R2 pulse length", 32'(hi_len), 32'(PC));

    // R3: each bit drives its own domain; bits 7..15 start nothing
    for (int i = 0; i < N; i++) begin
      cyc(1, 2'b10, 32'(1) << (16 + i), "R3 single bit");
      chk("R3 mapping", 32'(dom_rst), 32'(1) << i);
      idle(PC, "R3 drain");
    end
    cyc(1, 2'b10, 32'hFF80_0000, "R3 upper bits ignored");
    chk("R3 no reset from bits 7..15", 32'(dom_rst), 32'h0);

    // R4: all seven together
    cyc(1, 2'b10, 32'h007F_0000, "R4 all");
    chk("R4 all high", 32'(dom_rst), 32'h7F);
    idle(PC - 1, "R4 run");
    chk("R4 last cycle", 32'(dom_rst), 32'h7F);
    cyc(0, 2'b00, 0, "R4 end");
    chk("R4 all end together", 32'(dom_rst), 32'h0);

    // R6: restart one domain mid-pulse
    cyc(1, 2'b10, 32'h0005_0000, "R6 start");
    idle(30, "R6 mid");
    cyc(1, 2'b10, 32'h0004_0000, "R6 restart");
    idle(PC - 31, "R6 partial");
    chk("R6 domain 0 ended", 32'(dom_rst[0]), 32'h0);
    chk("R6 domain 2 still on", 32'(dom_rst[2]), 32'h1);
    idle(40, "R6 drain");

    // R8: forced interrupt
    cyc(1, 2'b01, 32'h0000_0200, "R8 force");
    chk("R8 pulse", 32'(irq_force), 32'h1);
    cyc(0, 2'b00, 0, "R8 one cycle");
    chk("R8 drop", 32'(irq_force), 32'h0);
    cyc(1, 2'b01, 32'h0000_FDFF, "R8 other lower bits");
    chk("R8 no pulse", 32'(irq_force), 32'h0);

    // R9: enables clear
    cyc(1, 2'b01, 32'h007F_0000, "R9 upper disabled");
    chk("R9 no reset", 32'(dom_rst), 32'h0);
    cyc(1, 2'b10, 32'h0000_0200, "R9 lower disabled");
    chk("R9 no irq", 32'(irq_force), 32'h0);
    cyc(0, 2'b11, 32'h007F_0200, "R9 wr_en low");
    chk("R9 wr_en low", 32'(dom_rst), 32'h0);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      bit en;
      logic [1:0] be;
      logic [31:0] d;
      en = ($urandom_range(0, 9) == 0);
      be = 2'($urandom);
      d  = $urandom;
      cyc(en, be, d, "random");
    end
    idle(PC + 2, "final drain");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule